// File: doc/BRIEF.md
# Stack and Jump Control Unit

This unit steers program flow for a 16-bit processor. It works in two ways. For a relative jump, it tests one of eight conditions against the carry, zero, negative and overflow flags held in the status word. It then produces either the branch target or the address of the next instruction word. For the stack operations, it runs push, pop, call, return and return-from-interrupt through a single-word memory port, and it reports the resulting stack pointer, program counter and status word.

The surrounding pipeline presents an operation with a one-cycle `start` pulse. It supplies the current PC, SP and status word, a 10-bit signed word offset, and an operand. The operand is the value to push or the call target. The unit raises `busy` and performs one memory access per cycle. It then pulses `done` for exactly one cycle, and during that cycle `pc_out`, `sp_out`, `sr_out` and `pop_data` carry the results. Operand addressing and arithmetic are handled elsewhere. The memory port returns read data combinationally in the cycle of the read strobe.

Top module: `flow_ctl`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `mem_we` and `mem_re` are all 0.
- R2: For a jump (`op`=0), the condition codes on `cond` behave as follows. Code 0 is taken when Z is clear, code 1 when Z is set, code 2 when C is clear, code 3 when C is set, and code 4 when N is set. The flags sit at status bits C=0, Z=1, N=2 and V=8.
- R3: Jump code 5 is taken when N XOR V is 0. Code 6 is taken when N XOR V is 1. Code 7 is always taken.
- R4: A taken jump gives `pc_out` = PC + 2 + 2×offset, with the 10-bit offset sign-extended. A jump not taken gives PC + 2. A jump completes with `done` one cycle after `start`, with no memory access, and with SP and the status word unchanged.
- R5: PUSH (`op`=1) makes one write of the operand, on all byte lanes (`mem_be`=11), at SP−2. `sp_out` is SP−2 and `done` follows two cycles after `start`.
- R6: A PUSH with `byte_mode`=1 writes only the low lane (`mem_be`=01), carries the operand's low byte in `mem_wdata[7:0]`, and still leaves `sp_out` at SP−2.
- R7: POP (`op`=2) makes one read at SP. `pop_data` is the word read, or its low byte zero-extended when `byte_mode`=1, and `sp_out` is SP+2.
- R8: CALL (`op`=3) writes PC+2 at SP−2, gives `sp_out` = SP−2, and loads the operand into `pc_out`.
- R9: RET (`op`=4) reads at SP, loads the word read into `pc_out`, and gives `sp_out` = SP+2.
- R10: RETI (`op`=5) makes two reads on consecutive cycles. The first, at SP, loads the status word. The second, at SP+2, loads the PC. `sp_out` ends at SP+4 and `done` follows three cycles after `start`.
- R11: `busy` is high from the cycle after `start` through the cycle of `done`, and `done` lasts one cycle. A `start` while busy is ignored. Operation codes 6 and 7 complete like a jump that is never taken and never advances the PC: `pc_out`, `sp_out` and `sr_out` equal the inputs, with no memory access.
- R12: `mem_we` and `mem_re` are never high together, and neither is high while the unit is idle or in its `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 3 | Operation: 0 jump, 1 push, 2 pop, 3 call, 4 return, 5 return-from-interrupt |
| cond | input | 3 | Jump condition code |
| offset | input | 10 | Signed jump distance in words |
| byte_mode | input | 1 | Byte-width push/pop |
| operand | input | 16 | Value to push, or call target |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| sr_in | input | 16 | Current status word |
| mem_rdata | input | 16 | Read data, valid in the cycle of `mem_re` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Results valid this cycle |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 16 | Resulting stack pointer |
| sr_out | output | 16 | Resulting status word |
| pop_data | output | 16 | Value popped |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_be | output | 2 | Byte-lane enables for writes |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |

## Verification
The bench builds the unit with its default 16-bit word and 10-bit offset. At that size every condition code can be swept against all sixteen combinations of the four flags. The sweep uses offsets that include zero, ±1 and the two extremes of the offset range, so the taken decision and the sign-extended target are checked for every case. The stack operations run against a small word memory model at several stack pointers. These runs cover byte-lane writes, a push followed by a pop, and a RETI that receives a second start pulse while it is still busy.

// File: rtl/flow_pkg.sv
// flow_pkg: shared encodings for the stack and jump control unit.
// Assumes status-word flag positions C=0, Z=1, N=2, V=8.
package flow_pkg;

    typedef enum logic [2:0] {
        OP_JUMP = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_RETI = 3'd5
    } flow_op_e;

    typedef enum logic [2:0] {
        CC_NZ  = 3'd0,
        CC_Z   = 3'd1,
        CC_NC  = 3'd2,
        CC_C   = 3'd3,
        CC_N   = 3'd4,
        CC_GE  = 3'd5,
        CC_LT  = 3'd6,
        CC_ALW = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC1 = 2'd1,
        ST_ACC2 = 2'd2,
        ST_DONE = 2'd3
    } seq_st_e;

    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 8;

endpackage

// File: rtl/flow_cond.sv
// flow_cond: decides whether a relative jump is taken.
// Purely combinational; assumes the flags are already extracted from the status word.
module flow_cond
    import flow_pkg::*;
(
    input  logic [2:0] cond,
    input  logic       flag_c,
    input  logic       flag_z,
    input  logic       flag_n,
    input  logic       flag_v,
    output logic       taken
);

    logic sign_mismatch;

    // Signed comparisons use the disagreement between sign and overflow.
    assign sign_mismatch = flag_n ^ flag_v;

    // Select the flag test named by the condition code.
    always_comb begin
        case (cond_e'(cond))
            CC_NZ:   taken = !flag_z;
            CC_Z:    taken = flag_z;
            CC_NC:   taken = !flag_c;
            CC_C:    taken = flag_c;
            CC_N:    taken = flag_n;
            CC_GE:   taken = !sign_mismatch;
            CC_LT:   taken = sign_mismatch;
            default: taken = 1'b1;
        endcase
    end

endmodule

// File: rtl/flow_target.sv
// flow_target: next PC for a jump, PC + 2 plus twice the signed word offset when taken.
// Assumes DW > OFFW so that the doubled offset fits in a word.
module flow_target #(
    parameter int DW   = 16,
    parameter int OFFW = 10
) (
    input  logic [DW-1:0]   pc,
    input  logic [OFFW-1:0] offset,
    input  logic            taken,
    output logic [DW-1:0]   next_pc
);

    localparam int PADW = DW - OFFW - 1;
    localparam logic [DW-1:0] STEP = {{(DW-2){1'b0}}, 2'b10};

    logic [DW-1:0] byte_dist;

    // Sign-extend and double the word offset; the variant depends on the spare width.
    generate
        if (PADW > 0) begin : g_pad
            assign byte_dist = {{PADW{offset[OFFW-1]}}, offset, 1'b0};
        end else begin : g_nopad
            assign byte_dist = {offset[DW-2:0], 1'b0};
        end
    endgenerate

    // Fall-through address, plus the distance when the jump is taken.
    assign next_pc = pc + STEP + (taken ? byte_dist : '0);

endmodule

// File: rtl/flow_seq.sv
// flow_seq: sequencer for jumps and stack operations with one memory access per state.
// Assumes mem_rdata is valid combinationally in the cycle mem_re is high.
module flow_seq
    import flow_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic          byte_mode,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] sr_in,
    input  logic [DW-1:0] jump_pc,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] sp_out,
    output logic [DW-1:0] sr_out,
    output logic [DW-1:0] pop_data,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW/8-1:0] mem_be,
    output logic          mem_we,
    output logic          mem_re
);

    localparam int LANES = DW / 8;
    localparam logic [DW-1:0] STEP = {{(DW-2){1'b0}}, 2'b10};
    localparam logic [LANES-1:0] LOW_LANE = {{(LANES-1){1'b0}}, 1'b1};

    seq_st_e       st_q;
    flow_op_e      op_q;
    logic          byte_q;
    logic [DW-1:0] opnd_q;
    logic [DW-1:0] pc_q;
    logic [DW-1:0] sp_q;
    logic [DW-1:0] sr_q;
    logic [DW-1:0] data_q;
    logic          is_write;
    logic          is_read;

    // Which operations write and which read in their first access.
    assign is_write = (op_q == OP_PUSH) || (op_q == OP_CALL);
    assign is_read  = (op_q == OP_POP) || (op_q == OP_RET) || (op_q == OP_RETI);

    // State and result registers advance one access per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_JUMP;
            byte_q <= 1'b0;
            opnd_q <= '0;
            pc_q   <= '0;
            sp_q   <= '0;
            sr_q   <= '0;
            data_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    op_q   <= flow_op_e'(op);
                    byte_q <= byte_mode;
                    opnd_q <= operand;
                    sp_q   <= sp_in;
                    sr_q   <= sr_in;
                    pc_q   <= (flow_op_e'(op) == OP_JUMP) ? jump_pc : pc_in;
                    if (op > 3'd0 && op < 3'd6) st_q <= ST_ACC1;
                    else                        st_q <= ST_DONE;
                end
                ST_ACC1: begin
                    st_q <= ST_DONE;
                    case (op_q)
                        OP_PUSH: sp_q <= sp_q - STEP;
                        OP_CALL: begin
                            sp_q <= sp_q - STEP;
                            pc_q <= opnd_q;
                        end
                        OP_POP: begin
                            data_q <= byte_q ? {{(DW-8){1'b0}}, mem_rdata[7:0]} : mem_rdata;
                            sp_q   <= sp_q + STEP;
                        end
                        OP_RET: begin
                            pc_q <= mem_rdata;
                            sp_q <= sp_q + STEP;
                        end
                        OP_RETI: begin
                            sr_q <= mem_rdata;
                            sp_q <= sp_q + STEP;
                            st_q <= ST_ACC2;
                        end
                        default: ;
                    endcase
                end
                ST_ACC2: begin
                    pc_q <= mem_rdata;
                    sp_q <= sp_q + STEP;
                    st_q <= ST_DONE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Memory strobes, address, data and lanes decoded from the current access state.
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp_q;
        mem_wdata = '0;
        mem_be    = '1;
        if (st_q == ST_ACC1 && is_write) begin
            mem_we   = 1'b1;
            mem_addr = sp_q - STEP;
            if (op_q == OP_CALL) begin
                mem_wdata = pc_q + STEP;
            end else if (byte_q) begin
                mem_wdata = {{(DW-8){1'b0}}, opnd_q[7:0]};
                mem_be    = LOW_LANE;
            end else begin
                mem_wdata = opnd_q;
            end
        end else if ((st_q == ST_ACC1 && is_read) || st_q == ST_ACC2) begin
            mem_re = 1'b1;
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign done     = (st_q == ST_DONE);
    assign pc_out   = pc_q;
    assign sp_out   = sp_q;
    assign sr_out   = sr_q;
    assign pop_data = data_q;

    // R12: read and write strobes are exclusive.
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R12: no access while idle or while reporting completion.
    p_quiet_edges_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || done) |-> (!mem_we && !mem_re));

    // R5: after a write, the stack pointer sits at the written address.
    p_write_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_out == $past(mem_addr)));

    // R7: after a read, the stack pointer is one word past the read address.
    p_read_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (sp_out == $past(mem_addr) + STEP));

    // R10: the second RETI read follows the first one word higher.
    p_reti_second_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + STEP));

    // R11: completion is a single-cycle pulse.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a partial-lane write carries nothing above the low byte.
    p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be != '1) |-> (mem_wdata[DW-1:8] == '0));

endmodule

// File: rtl/flow_ctl.sv
// flow_ctl: top of the stack and jump control unit.
// Assumes start is only acted on while idle; results are valid while done is high.
module flow_ctl
    import flow_pkg::*;
#(
    parameter int DW   = 16,
    parameter int OFFW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [2:0]    cond,
    input  logic [OFFW-1:0] offset,
    input  logic          byte_mode,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] sr_in,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] sp_out,
    output logic [DW-1:0] sr_out,
    output logic [DW-1:0] pop_data,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW/8-1:0] mem_be,
    output logic          mem_we,
    output logic          mem_re
);

    logic          taken;
    logic [DW-1:0] jump_pc;

    flow_cond u_cond (
        .cond   (cond),
        .flag_c (sr_in[FLAG_C]),
        .flag_z (sr_in[FLAG_Z]),
        .flag_n (sr_in[FLAG_N]),
        .flag_v (sr_in[FLAG_V]),
        .taken  (taken)
    );

    flow_target #(.DW(DW), .OFFW(OFFW)) u_target (
        .pc      (pc_in),
        .offset  (offset),
        .taken   (taken),
        .next_pc (jump_pc)
    );

    flow_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .byte_mode (byte_mode),
        .operand   (operand),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .sr_in     (sr_in),
        .jump_pc   (jump_pc),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .pc_out    (pc_out),
        .sp_out    (sp_out),
        .sr_out    (sr_out),
        .pop_data  (pop_data),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .mem_we    (mem_we),
        .mem_re    (mem_re)
    );

    // R4: a jump started from idle completes on the very next cycle.
    p_jump_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 3'd0) |=> done);

endmodule

// File: tb/flow_ctl_tb_top.sv
module flow_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [2:0]  op;
    logic [2:0]  cond;
    logic [9:0]  offset;
    logic        byte_mode;
    logic [15:0] operand, pc_in, sp_in, sr_in, mem_rdata;
    logic        busy, done, mem_we, mem_re;
    logic [15:0] pc_out, sp_out, sr_out, pop_data, mem_addr, mem_wdata;
    logic [1:0]  mem_be;

    always #10 clk = ~clk;

    flow_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond(cond),
        .offset(offset), .byte_mode(byte_mode), .operand(operand),
        .pc_in(pc_in), .sp_in(sp_in), .sr_in(sr_in), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
        .sr_out(sr_out), .pop_data(pop_data), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_we(mem_we), .mem_re(mem_re)
    );

    // Word memory model, combinational read, lane-masked write.
    logic [15:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[8:1]];
    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_be[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Observations of one operation.
    int          n_wr, n_rd, lat, bad_busy, edge_strobe;
    logic [15:0] wr_addr, wr_data, rd_addr0, rd_addr1;
    logic [1:0]  wr_be;

    task automatic run(input logic [2:0] o, input logic [2:0] c, input logic [9:0] off,
                       input logic bm, input logic [15:0] opnd, input logic [15:0] pc,
                       input logic [15:0] sp, input logic [15:0] sr, input bit glitch);
        @(negedge clk);
        op = o; cond = c; offset = off; byte_mode = bm; operand = opnd;
        pc_in = pc; sp_in = sp; sr_in = sr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_wr = 0; n_rd = 0; lat = 1; bad_busy = 0; edge_strobe = 0;
        forever begin
            if (!busy) bad_busy++;
            if (mem_we) begin n_wr++; wr_addr = mem_addr; wr_data = mem_wdata; wr_be = mem_be; end
            if (mem_re) begin
                if (n_rd == 0) rd_addr0 = mem_addr; else rd_addr1 = mem_addr;
                n_rd++;
            end
            if (done) begin
                if (mem_we || mem_re) edge_strobe++;
                break;
            end
            if (lat > 8) begin
                chk("R11 watchdog on done", 32'(lat), 32'd3);
                break;
            end
            if (glitch && lat == 1) begin start = 1'b1; op = 3'd1; end
            else start = 1'b0;
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
    endtask

    function automatic bit jump_taken(input int cc, input logic [3:0] f);
        bit c = f[0], z = f[1], n = f[2], v = f[3];
        case (cc)
            0: return !z;
            1: return z;
            2: return !c;
            3: return c;
            4: return n;
            5: return (n ^ v) == 1'b0;
            6: return (n ^ v) == 1'b1;
            default: return 1'b1;
        endcase
    endfunction

    bit finished = 0;

    initial begin
        int offs [6] = '{0, 1, -1, 511, -512, 37};
        rst_n = 1'b0; start = 1'b0; op = '0; cond = '0; offset = '0; byte_mode = 1'b0;
        operand = '0; pc_in = '0; sp_in = '0; sr_in = '0;
        for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 strobes", 32'({mem_we, mem_re}), 0);

        // R2 R3 R4: every condition code against every flag pattern and offsets.
        for (int cc = 0; cc < 8; cc++) begin
            for (int f = 0; f < 16; f++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [3:0]  fl = 4'(f);
                    logic [15:0] sr = {7'd0, fl[3], 5'd0, fl[2], fl[1], fl[0]};
                    logic [15:0] pc = 16'h4000 + 16'(cc * 64);
                    logic [15:0] exp_pc;
                    exp_pc = jump_taken(cc, fl) ? 16'(int'(pc) + 2 + 2 * offs[k]) : pc + 16'd2;
                    run(3'd0, 3'(cc), 10'(offs[k]), 1'b0, 16'h1234, pc, 16'h0100, sr, 0);
                    chk(cc < 5 ? "R2 R4 pc_out" : "R3 R4 pc_out", 32'(pc_out), 32'(exp_pc));
                    chk("R4 latency and no access", 32'({lat[3:0], 4'(n_wr + n_rd)}), 32'h10);
                    chk("R4 sp/sr unchanged", {sp_out, sr_out}, {16'h0100, sr});
                end
            end
        end

        // R5 word push at several stack pointers; R12 strobes.
        for (int s = 0; s < 4; s++) begin
            logic [15:0] sp = 16'h0100 + 16'(s * 32);
            logic [15:0] val = 16'hBEE0 + 16'(s);
            run(3'd1, 3'd0, 10'd0, 1'b0, val, 16'h2000, sp, 16'h0007, 0);
            chk("R5 write count", 32'(n_wr), 1);
            chk("R5 write addr", 32'(wr_addr), 32'(sp - 16'd2));
            chk("R5 write data", 32'(wr_data), 32'(val));
            chk("R5 lanes", 32'(wr_be), 32'h3);
            chk("R5 sp_out", 32'(sp_out), 32'(sp - 16'd2));
            chk("R5 latency", 32'(lat), 2);
            chk("R12 no read, quiet done", 32'(n_rd + edge_strobe), 0);
            @(negedge clk);
            chk("R5 memory", 32'(mem[(sp - 16'd2) >> 1]), 32'(val));
            // R7 pop of the same word returns it
            run(3'd2, 3'd0, 10'd0, 1'b0, 16'h0, 16'h2000, sp - 16'd2, 16'h0, 0);
            chk("R7 pop_data", 32'(pop_data), 32'(val));
            chk("R7 read addr", 32'(rd_addr0), 32'(sp - 16'd2));
            chk("R7 sp_out", 32'(sp_out), 32'(sp));
            chk("R7 one read", 32'(n_rd + n_wr), 1);
        end

        // R6 byte push touches only the low lane.
        mem[16'h00C0 >> 1] = 16'hFFFF;
        run(3'd1, 3'd0, 10'd0, 1'b1, 16'h12A5, 16'h2000, 16'h00C2, 16'h0, 0);
        chk("R6 lanes", 32'(wr_be), 32'h1);
        chk("R6 low byte", 32'(wr_data[7:0]), 32'hA5);
        chk("R6 sp_out", 32'(sp_out), 32'h00C0);
        @(negedge clk);
        chk("R6 memory", 32'(mem[16'h00C0 >> 1]), 32'hFFA5);

        // R7 byte pop zero-extends.
        mem[16'h00D0 >> 1] = 16'h4C3D;
        run(3'd2, 3'd0, 10'd0, 1'b1, 16'h0, 16'h2000, 16'h00D0, 16'h0, 0);
        chk("R7 byte pop_data", 32'(pop_data), 32'h003D);
        chk("R7 byte sp_out", 32'(sp_out), 32'h00D2);

        // R8 call.
        run(3'd3, 3'd0, 10'd0, 1'b0, 16'h5550, 16'h3000, 16'h0120, 16'h0, 0);
        chk("R8 write addr", 32'(wr_addr), 32'h011E);
        chk("R8 return addr", 32'(wr_data), 32'h3002);
        chk("R8 pc_out", 32'(pc_out), 32'h5550);
        chk("R8 sp_out", 32'(sp_out), 32'h011E);

        // R9 return.
        mem[16'h0140 >> 1] = 16'h7776;
        run(3'd4, 3'd0, 10'd0, 1'b0, 16'h0, 16'h3000, 16'h0140, 16'h0, 0);
        chk("R9 pc_out", 32'(pc_out), 32'h7776);
        chk("R9 sp_out", 32'(sp_out), 32'h0142);
        chk("R9 read addr", 32'(rd_addr0), 32'h0140);

        // R10 return-from-interrupt, plus R11 start while busy.
        for (int g = 0; g < 2; g++) begin
            mem[16'h0160 >> 1] = 16'h0105;
            mem[16'h0162 >> 1] = 16'h8888;
            run(3'd5, 3'd0, 10'd0, 1'b0, 16'h0, 16'h3000, 16'h0160, 16'h0002, g == 1);
            chk("R10 sr_out", 32'(sr_out), 32'h0105);
            chk("R10 pc_out", 32'(pc_out), 32'h8888);
            chk("R10 sp_out", 32'(sp_out), 32'h0164);
            chk("R10 read order", {rd_addr0, rd_addr1}, 32'h01600162);
            chk("R10 two reads", 32'(n_rd), 2);
            chk("R10 latency", 32'(lat), 3);
            chk("R11 busy held", 32'(bad_busy), 0);
            chk("R11 no write from ignored start", 32'(n_wr), 0);
            @(negedge clk);
            chk("R11 idle after done", 32'({busy, done, mem_we}), 0);
        end

        // R11 undefined operation codes pass everything through.
        for (int u = 6; u < 8; u++) begin
            run(3'(u), 3'd7, 10'd5, 1'b0, 16'h9999, 16'h1110, 16'h0150, 16'h0104, 0);
            chk("R11 undefined op passthrough", {pc_out, sp_out}, {16'h1110, 16'h0150});
            chk("R11 undefined op sr/latency", {sr_out, 16'(lat)}, {16'h0104, 16'd1});
            chk("R11 undefined op no access", 32'(n_rd + n_wr), 0);
        end

        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL R11 watchdog expired actual=hung expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule